// File: doc/BRIEF.md
# Sprite Memory DMA Engine

This engine copies one 256-byte page of processor address space into the sprite attribute memory. The processor starts a copy by writing a page number to the trigger register. That write reaches the engine as a one-cycle start strobe, together with the page byte and a one-bit parity flag for the current processor cycle. The engine then holds the processor in a stall. It waits one or two alignment cycles, chosen by the parity flag, and after that runs strictly alternating read and write cycles.

In each read cycle the engine drives a request and an address onto the system bus and captures the byte that comes back in the same cycle. In the following cycle it issues a write strobe carrying that byte to the sprite-data register of the register interface. Because the write goes through that register, the byte lands at the current sprite address, which then steps forward.

The engine always runs a fixed schedule. Nothing on either side can apply back-pressure: the bus must return read data in the cycle of the request, and the register interface must accept every write strobe. The only flow control is the stall line, which holds the processor off the bus. One cycle after the last write, the engine gives a single-cycle done pulse and returns to idle.

Top module: `spr_dma`

## Requirements
- R1: While reset is asserted and directly after it, `stall_o`, `rd_req_o`, `wr_stb_o` and `done_o` are all low.
- R2: When a start strobe is accepted, `parity_odd_i` is sampled with it. The number of stalled cycles before the first read cycle is 1 when that bit is high (odd) and 2 when it is low (even).
- R3: The read cycles present `rd_addr_o` = {page byte, offset} in bits [15:8] and [7:0], with the offset going 0, 1, ..., 255 in ascending order.
- R4: Every read cycle is followed at once by a write cycle, and every write cycle comes right after a read cycle. `wr_data_o` in a write cycle equals the `rd_data_i` byte presented in the read cycle before it.
- R5: `stall_o` rises in the cycle after the accepting clock edge and stays high without a gap through the last write cycle: 513 cycles for odd parity, 514 for even.
- R6: One transfer makes exactly 256 read cycles and 256 write cycles.
- R7: `done_o` is high for exactly one cycle, the cycle right after the last write, with `stall_o` low in that cycle. A new start strobe is accepted in that same cycle.
- R8: A start strobe that arrives while `stall_o` is high is ignored. The page, the parity alignment and the length of the running transfer stay unchanged.
- R9: `rd_req_o` and `wr_stb_o` are never high together, and neither is high while `stall_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start strobe from the trigger register write |
| page_i | input | 8 | Source page number, sampled with the start strobe |
| parity_odd_i | input | 1 | High when the current processor cycle count is odd |
| stall_o | output | 1 | Holds the processor off the bus while a transfer runs |
| rd_req_o | output | 1 | System bus read request |
| rd_addr_o | output | 16 | System bus read address |
| rd_data_i | input | 8 | Byte returned by the bus in the cycle of the request |
| wr_stb_o | output | 1 | Write strobe to the sprite-data register |
| wr_data_o | output | 8 | Byte written to the sprite-data register |
| done_o | output | 1 | One-cycle pulse after the last write |

## Verification
The bench runs the copy for the lowest page, the highest page and two mixed bit patterns, each under both parity values. This separates a fault in the alignment count from a fault in page handling or in the offset order. The bus model returns a byte computed from both halves of the address, so a swapped, stale or skipped read shows up as a data mismatch on the write side. Some runs inject a second start strobe with the page and parity inverted in the middle of the transfer, which shows whether a busy engine reloads anything. Runs are chained back to back, each started in the done cycle of the one before, which exercises the return to idle.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } dma_state_e;
endpackage

// File: rtl/spr_dma_sched.sv
module spr_dma_sched
  import spr_dma_pkg::*;
#(
  parameter int ALIGN_ODD  = 1,
  parameter int ALIGN_EVEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       parity_odd_i,
  input  logic       last_ofs_i,
  output dma_state_e state_o,
  output logic       accept_o,
  output logic       step_o,
  output logic       done_o
);
  localparam int ALIGN_MAX = (ALIGN_ODD > ALIGN_EVEN) ? ALIGN_ODD : ALIGN_EVEN;
  localparam int CNT_W     = $clog2(ALIGN_MAX + 1);

  dma_state_e       state_q;
  logic [CNT_W-1:0] align_q;
  logic             done_q;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign step_o   = (state_q == ST_WRITE);
  assign state_o  = state_q;
  assign done_o   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      align_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_WRITE) && last_ofs_i;
      case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            state_q <= ST_ALIGN;
            align_q <= parity_odd_i ? CNT_W'(ALIGN_ODD) : CNT_W'(ALIGN_EVEN);
          end
        end
        ST_ALIGN: begin
          if (align_q <= CNT_W'(1)) state_q <= ST_READ;
          else                      align_q <= align_q - CNT_W'(1);
        end
        ST_READ:  state_q <= ST_WRITE;
        ST_WRITE: state_q <= last_ofs_i ? ST_IDLE : ST_READ;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spr_dma_addr.sv
module spr_dma_addr #(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic                    step_i,
  output logic [PAGE_W+OFS_W-1:0] addr_o,
  output logic                    last_o
);
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      ofs_q  <= '0;
    end else if (load_i) begin
      page_q <= page_i;
      ofs_q  <= '0;
    end else if (step_i) begin
      ofs_q  <= ofs_q + OFS_W'(1);
    end
  end

  assign addr_o = {page_q, ofs_q};
  assign last_o = &ofs_q;
endmodule

// File: rtl/spr_dma_hold.sv
module spr_dma_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)         q <= '0;
    else if (capture_i) q <= d_i;
  end

  assign q_o = q;
endmodule

// File: rtl/spr_dma.sv
module spr_dma
  import spr_dma_pkg::*;
#(
  parameter int PAGE_W     = 8,
  parameter int OFS_W      = 8,
  parameter int DATA_W     = 8,
  parameter int ALIGN_ODD  = 1,
  parameter int ALIGN_EVEN = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic                    parity_odd_i,
  output logic                    stall_o,
  output logic                    rd_req_o,
  output logic [PAGE_W+OFS_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0]       rd_data_i,
  output logic                    wr_stb_o,
  output logic [DATA_W-1:0]       wr_data_o,
  output logic                    done_o
);
  dma_state_e state;
  logic       accept;
  logic       step;
  logic       last_ofs;

  spr_dma_sched #(
    .ALIGN_ODD (ALIGN_ODD),
    .ALIGN_EVEN(ALIGN_EVEN)
  ) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .parity_odd_i(parity_odd_i),
    .last_ofs_i  (last_ofs),
    .state_o     (state),
    .accept_o    (accept),
    .step_o      (step),
    .done_o      (done_o)
  );

  spr_dma_addr #(
    .PAGE_W(PAGE_W),
    .OFS_W (OFS_W)
  ) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(accept),
    .page_i(page_i),
    .step_i(step),
    .addr_o(rd_addr_o),
    .last_o(last_ofs)
  );

  spr_dma_hold #(
    .DATA_W(DATA_W)
  ) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture_i(rd_req_o),
    .d_i      (rd_data_i),
    .q_o      (wr_data_o)
  );

  assign stall_o  = (state != ST_IDLE);
  assign rd_req_o = (state == ST_READ);
  assign wr_stb_o = (state == ST_WRITE);
endmodule

// File: rtl/spr_dma_chk.sv
module spr_dma_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall_o,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              wr_stb_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              done_o
);
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_o && wr_stb_o));
  p_in_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o || wr_stb_o) |-> stall_o);
  p_alternate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> wr_stb_o);
  p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> $past(rd_req_o));
  p_wr_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> (wr_data_o == $past(rd_data_i)));
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && $past(wr_stb_o)) |->
      (rd_addr_o == $past(rd_addr_o) + ADDR_W'(1)));
  p_page_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && $past(stall_o)) |->
      $stable(rd_addr_o[ADDR_W-1:ADDR_W-PAGE_W]));
  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!stall_o && $past(wr_stb_o)));
  p_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_o) |-> done_o);
endmodule

bind spr_dma spr_dma_chk #(
  .ADDR_W(PAGE_W + OFS_W),
  .DATA_W(DATA_W),
  .PAGE_W(PAGE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stall_o  (stall_o),
  .rd_req_o (rd_req_o),
  .rd_addr_o(rd_addr_o),
  .rd_data_i(rd_data_i),
  .wr_stb_o (wr_stb_o),
  .wr_data_o(wr_data_o),
  .done_o   (done_o)
);

// File: tb/spr_dma_tb.sv
`timescale 1ns/1ps
module spr_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  page_i = 8'h00;
  logic        parity_odd_i = 1'b0;
  logic        stall_o, rd_req_o, wr_stb_o, done_o;
  logic [15:0] rd_addr_o;
  logic [7:0]  rd_data_i, wr_data_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return 8'(a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  assign rd_data_i = mem_byte(rd_addr_o);

  spr_dma u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_i(page_i),
    .parity_odd_i(parity_odd_i), .stall_o(stall_o), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .wr_stb_o(wr_stb_o),
    .wr_data_o(wr_data_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic run_dma(input logic [7:0] pg, input bit odd, input bit poke);
    int stall_n = 0, idle_n = -1, rds = 0, wrs = 0;
    int bad_addr = 0, bad_data = 0, bad_alt = 0, bad_excl = 0;
    int last_wr = -1, done_at = -1, k = 1;
    bit prev_rd = 1'b0, done_stall = 1'b0;
    logic [7:0] prev_data = 8'h00;
    start_i = 1'b1; page_i = pg; parity_odd_i = odd;
    @(negedge clk);
    start_i = 1'b0; page_i = ~pg; parity_odd_i = ~odd;
    while (k < 700) begin
      if (stall_o) stall_n++;
      if (rd_req_o && wr_stb_o) bad_excl++;
      if ((rd_req_o || wr_stb_o) && !stall_o) bad_excl++;
      if (rd_req_o) begin
        if (idle_n < 0) idle_n = stall_n - 1;
        if (rd_addr_o != {pg, 8'(rds)}) bad_addr++;
        if (prev_rd) bad_alt++;
        prev_data = mem_byte(rd_addr_o);
        rds++;
      end
      if (wr_stb_o) begin
        if (!prev_rd) bad_alt++;
        if (wr_data_o != prev_data) bad_data++;
        wrs++;
        last_wr = k;
      end
      prev_rd = rd_req_o;
      if (done_o) begin
        done_at = k;
        done_stall = stall_o;
        break;
      end
      if (poke && k == 100) begin
        start_i = 1'b1; page_i = ~pg; parity_odd_i = ~odd;
      end else begin
        start_i = 1'b0;
      end
      k++;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(idle_n == (odd ? 1 : 2), $sformatf("R2 align pg=%0h odd=%0d", pg, odd), idle_n, odd ? 1 : 2);
    chk(stall_n == (odd ? 513 : 514), $sformatf("R5 stall length pg=%0h", pg), stall_n, odd ? 513 : 514);
    chk(rds == 256, "R6 read count", rds, 256);
    chk(wrs == 256, "R6 write count", wrs, 256);
    chk(bad_addr == 0, $sformatf("R3 address order pg=%0h", pg), bad_addr, 0);
    chk(bad_alt == 0 && bad_data == 0, "R4 alternation/data", bad_alt + bad_data, 0);
    chk(bad_excl == 0, "R9 strobe exclusivity", bad_excl, 0);
    chk(done_at == last_wr + 1 && !done_stall, "R7 done timing", done_at, last_wr + 1);
    if (poke)
      chk(bad_addr == 0 && stall_n == (odd ? 513 : 514), "R8 busy start ignored",
          stall_n, odd ? 513 : 514);
  endtask

  initial begin
    #(200000 * 5.0);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!stall_o && !rd_req_o && !wr_stb_o && !done_o, "R1 in reset",
        int'({stall_o, rd_req_o, wr_stb_o, done_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stall_o && !rd_req_o && !wr_stb_o && !done_o, "R1 after reset",
        int'({stall_o, rd_req_o, wr_stb_o, done_o}), 0);
    run_dma(8'h00, 1'b1, 1'b0);
    run_dma(8'h00, 1'b0, 1'b0);
    run_dma(8'hFF, 1'b1, 1'b1);
    run_dma(8'hFF, 1'b0, 1'b0);
    run_dma(8'h5A, 1'b0, 1'b1);
    run_dma(8'h5A, 1'b1, 1'b0);
    run_dma(8'h81, 1'b1, 1'b0);
    run_dma(8'h81, 1'b0, 1'b1);
    @(negedge clk);
    chk(!done_o, "R7 done single cycle", int'(done_o), 0);
    chk(!stall_o && !rd_req_o && !wr_stb_o, "R9 idle after transfer",
        int'({stall_o, rd_req_o, wr_stb_o}), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule